// File: doc/BRIEF.md
# Alternate Register-Write Routing Translator

This block sits between a CPU write bus and the register port of a scanline-interrupt bank-switching controller. An operation-mode value selects between two layouts. When the mode value is zero, every write in the upper half of the address space goes to the controller unchanged. When the mode value is nonzero, writes in the `0x8000`–`0xBFFF` window are rerouted to other controller functions. In that window the even/odd roles are swapped, and the bank-select index is scrambled through a fixed permutation.

Bank-data writes in the alternate layout are gated by a staging flag. A bank-select write sets the flag and records the permuted index. A bank-data write is forwarded only while the flag is set. While the fixed-block override is active, a bank-data write is also blocked when the recorded index names a program register (index 6 or 7).

Each accepted CPU write produces at most one translated write strobe. The strobe carries a function code, a canonical controller address and data, and lasts one clock. A separate output holds the nametable mirroring bit.

Top module: `write_route_xlate`

## Requirements
- R1: A translated strobe `ctl_we_o` is high for exactly one clock, in the cycle after a clock edge that sampled `cpu_we_i` high. No strobe follows a clock with `cpu_we_i` low, and no strobe follows a write whose address is below `0x8000`.
- R2: With `mode_reg_i` equal to zero, a write anywhere in `0x8000`–`0xFFFF` is forwarded with function code 0 (pass). The address and data are unchanged.
- R3: A write in `0xC000`–`0xFFFF` is forwarded with function code 0, with address and data unchanged, whatever the mode value.
- R4: With a nonzero mode value, a write whose address ANDed with `0xE001` equals `0x8000` is forwarded with function code 3 (interrupt latch). Its address is `0xC000` and its data is unchanged.
- R5: With a nonzero mode value, a write whose masked address equals `0x8001` is forwarded with function code 1 (bank select) and address `0x8000`. The data is built from three parts:
  - bits 7:6 are copied from the input;
  - bits 5:3 are zero;
  - bits 2:0 are `P[d[2:0]]`, where P is 0→0, 1→6, 2→3, 3→7, 4→5, 5→2, 6→4, 7→1.
- R6: The R5 write sets the staging flag and records `P[d[2:0]]`. A later write whose masked address equals `0xA000` is forwarded when the flag is set and either `fixed_blk_i` is low or the recorded index is below 6. It goes out with function code 2 (bank data), address `0x8001` and unchanged data, and it clears the flag.
- R7: A masked-`0xA000` write is dropped with no strobe in two cases: when the staging flag is clear, or when `fixed_blk_i` is high and the recorded index is 6 or 7. A write dropped for the second reason leaves the flag set.
- R8: With a nonzero mode value, a write whose masked address equals `0xA001` produces no strobe and sets `mirror_h_o` to data bit 0 on the next clock (1 = horizontal, 0 = vertical). `mirror_h_o` changes at no other time.
- R9: While `rst_ni` is low, `ctl_we_o`, `ctl_fn_o`, `ctl_addr_o`, `ctl_data_o` and `mirror_h_o` are all zero, and the staging flag and recorded index are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU write address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | CPU write strobe, one write per high cycle |
| mode_reg_i | input | 8 | Operation-mode value; nonzero selects the alternate layout |
| fixed_blk_i | input | 1 | Fixed-block override active |
| ctl_we_o | output | 1 | Translated one-cycle write strobe |
| ctl_fn_o | output | 2 | Function code: 0 pass, 1 bank select, 2 bank data, 3 interrupt latch |
| ctl_addr_o | output | 16 | Controller address: the original address for pass, otherwise canonical |
| ctl_data_o | output | 8 | Translated write data |
| mirror_h_o | output | 1 | Mirroring: 1 horizontal, 0 vertical |

## Verification
A wrong staging flag or recorded index is invisible until the next masked-`0xA000` write. At that point it shows up one clock later in one of two ways: a bank-data strobe that should not exist, or a missing strobe. For that reason the bench always follows each staging write with a probe data write, and it repeats the probe with the override both on and off. A wrong permutation entry shows at once in bits 2:0 of the bank-select strobe, so all eight index values are driven. A wrong mirroring register shows on `mirror_h_o` in the cycle after any write, because the bench compares that output on every clock.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned KEEP_W = 2;

  typedef enum logic [1:0] {
    FN_PASS  = 2'd0,
    FN_BSEL  = 2'd1,
    FN_BDATA = 2'd2,
    FN_IRQL  = 2'd3
  } ctl_fn_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PASS,
    RG_IRQL,
    RG_BSEL,
    RG_BDATA,
    RG_MIRR
  } route_e;
endpackage

// File: rtl/xlate_decode.sv
module xlate_decode
  import xlate_pkg::*;
#(
  parameter int unsigned MODE_W = 8
) (
  input  logic              we_i,
  input  logic [2:0]        addr_hi_i,  // top three address bits
  input  logic              addr_odd_i,
  input  logic [MODE_W-1:0] mode_i,
  output route_e            route_o
);
  logic alt_mode;
  assign alt_mode = |mode_i;

  always_comb begin
    route_o = RG_NONE;
    if (we_i && addr_hi_i[2]) begin
      if (!alt_mode || addr_hi_i[1]) begin
        route_o = RG_PASS;
      end else begin
        unique case ({addr_hi_i[0], addr_odd_i})
          2'b00:   route_o = RG_IRQL;
          2'b01:   route_o = RG_BSEL;
          2'b10:   route_o = RG_BDATA;
          default: route_o = RG_MIRR;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlate_permute.sv
module xlate_permute
  import xlate_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [KEEP_W-1:0] keep_i,
  input  logic [SEL_W-1:0]  idx_i,
  output logic [SEL_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned GAP_W = DATA_W - KEEP_W - SEL_W;

  always_comb begin
    unique case (idx_i)
      3'd0: idx_o = 3'd0;
      3'd1: idx_o = 3'd6;
      3'd2: idx_o = 3'd3;
      3'd3: idx_o = 3'd7;
      3'd4: idx_o = 3'd5;
      3'd5: idx_o = 3'd2;
      3'd6: idx_o = 3'd4;
      default: idx_o = 3'd1;
    endcase
  end

  generate
    if (GAP_W > 0) begin : g_gap
      assign data_o = {keep_i, {GAP_W{1'b0}}, idx_o};
    end else begin : g_nogap
      assign data_o = {keep_i, idx_o};
    end
  endgenerate
endmodule

// File: rtl/xlate_stage.sv
module xlate_stage
  import xlate_pkg::*;
#(
  parameter int unsigned PRG_IDX_MIN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [SEL_W-1:0] idx_i,
  input  logic             try_i,
  input  logic             fixed_i,
  output logic             grant_o
);
  localparam logic [SEL_W-1:0] PRG_MIN = SEL_W'(PRG_IDX_MIN);

  logic             pend_q;
  logic [SEL_W-1:0] idx_q;

  // program-register writes are held off while the fixed block is forced
  assign grant_o = try_i && pend_q && (!fixed_i || (idx_q < PRG_MIN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      idx_q  <= '0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      idx_q  <= idx_i;
    end else if (grant_o) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/write_route_xlate.sv
module write_route_xlate
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned MODE_W      = 8,
  parameter int unsigned PRG_IDX_MIN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  input  logic              cpu_we_i,
  input  logic [MODE_W-1:0] mode_reg_i,
  input  logic              fixed_blk_i,
  output logic              ctl_we_o,
  output logic [1:0]        ctl_fn_o,
  output logic [ADDR_W-1:0] ctl_addr_o,
  output logic [DATA_W-1:0] ctl_data_o,
  output logic              mirror_h_o
);
  localparam logic [ADDR_W-1:0] A_BSEL  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] A_BDATA = {1'b1, {(ADDR_W-2){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] A_IRQL  = {2'b11, {(ADDR_W-2){1'b0}}};

  route_e            route;
  logic [SEL_W-1:0]  perm_idx;
  logic [DATA_W-1:0] perm_data;
  logic              grant;

  ctl_fn_e           fn_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              mir_q;

  xlate_decode #(.MODE_W(MODE_W)) u_decode (
    .we_i      (cpu_we_i),
    .addr_hi_i (cpu_addr_i[ADDR_W-1 -: 3]),
    .addr_odd_i(cpu_addr_i[0]),
    .mode_i    (mode_reg_i),
    .route_o   (route)
  );

  xlate_permute #(.DATA_W(DATA_W)) u_permute (
    .keep_i(cpu_data_i[DATA_W-1 -: KEEP_W]),
    .idx_i (cpu_data_i[SEL_W-1:0]),
    .idx_o (perm_idx),
    .data_o(perm_data)
  );

  xlate_stage #(.PRG_IDX_MIN(PRG_IDX_MIN)) u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (route == RG_BSEL),
    .idx_i  (perm_idx),
    .try_i  (route == RG_BDATA),
    .fixed_i(fixed_blk_i),
    .grant_o(grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      fn_q   <= FN_PASS;
      addr_q <= '0;
      data_q <= '0;
      mir_q  <= 1'b0;
    end else begin
      we_q <= 1'b0;
      unique case (route)
        RG_PASS: begin
          we_q   <= 1'b1;
          fn_q   <= FN_PASS;
          addr_q <= cpu_addr_i;
          data_q <= cpu_data_i;
        end
        RG_IRQL: begin
          we_q   <= 1'b1;
          fn_q   <= FN_IRQL;
          addr_q <= A_IRQL;
          data_q <= cpu_data_i;
        end
        RG_BSEL: begin
          we_q   <= 1'b1;
          fn_q   <= FN_BSEL;
          addr_q <= A_BSEL;
          data_q <= perm_data;
        end
        RG_BDATA: begin
          if (grant) begin
            we_q   <= 1'b1;
            fn_q   <= FN_BDATA;
            addr_q <= A_BDATA;
            data_q <= cpu_data_i;
          end
        end
        RG_MIRR: mir_q <= cpu_data_i[0];
        default: ;
      endcase
    end
  end

  assign ctl_we_o   = we_q;
  assign ctl_fn_o   = fn_q;
  assign ctl_addr_o = addr_q;
  assign ctl_data_o = data_q;
  assign mirror_h_o = mir_q;
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_data_i,
  input logic              cpu_we_i,
  input logic [MODE_W-1:0] mode_reg_i,
  input logic              ctl_we_o,
  input logic [1:0]        ctl_fn_o,
  input logic [ADDR_W-1:0] ctl_addr_o,
  input logic [DATA_W-1:0] ctl_data_o,
  input logic              mirror_h_o
);
  localparam logic [ADDR_W-1:0] A_BSEL  = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] A_BDATA = {1'b1, {(ADDR_W-2){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] A_IRQL  = {2'b11, {(ADDR_W-2){1'b0}}};

  logic alt, hi, top, sub_a, odd, mir_wr;
  assign alt    = |mode_reg_i;
  assign hi     = cpu_addr_i[ADDR_W-1];
  assign top    = cpu_addr_i[ADDR_W-2];
  assign sub_a  = cpu_addr_i[ADDR_W-3];
  assign odd    = cpu_addr_i[0];
  assign mir_wr = cpu_we_i && alt && hi && !top && sub_a && odd;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cpu_we_i) |-> !ctl_we_o);

  // R1
  low_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_we_i && !hi) |-> !ctl_we_o);

  // R2
  pass_mode_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_we_i && hi && !alt) |->
      ctl_we_o && ctl_fn_o == 2'd0 && ctl_addr_o == $past(cpu_addr_i)
      && ctl_data_o == $past(cpu_data_i));

  // R3
  pass_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_we_i && hi && top) |->
      ctl_we_o && ctl_fn_o == 2'd0 && ctl_addr_o == $past(cpu_addr_i)
      && ctl_data_o == $past(cpu_data_i));

  // R4
  irq_latch_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_we_i && alt && hi && !top && !sub_a && !odd) |->
      ctl_we_o && ctl_fn_o == 2'd3 && ctl_addr_o == A_IRQL
      && ctl_data_o == $past(cpu_data_i));

  // R5
  bank_sel_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cpu_we_i && alt && hi && !top && !sub_a && odd) |->
      ctl_we_o && ctl_fn_o == 2'd1 && ctl_addr_o == A_BSEL
      && ctl_data_o[5:3] == 3'b000 && ctl_data_o[7:6] == $past(cpu_data_i[7:6]));

  // R6
  bank_data_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_o && ctl_fn_o == 2'd2) |->
      $past(cpu_we_i && alt && hi && !top && sub_a && !odd)
      && ctl_addr_o == A_BDATA && ctl_data_o == $past(cpu_data_i));

  // R8
  mirror_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mir_wr) |-> mirror_h_o == $past(cpu_data_i[0]) && !ctl_we_o);

  // R8
  mirror_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(mir_wr) |-> $stable(mirror_h_o));
endmodule

bind write_route_xlate xlate_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/tb_write_route_xlate.sv
`timescale 1ns/1ps
module tb_write_route_xlate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic        cpu_we_i = 1'b0;
  logic [7:0]  mode_reg_i = '0;
  logic        fixed_blk_i = 1'b0;
  logic        ctl_we_o;
  logic [1:0]  ctl_fn_o;
  logic [15:0] ctl_addr_o;
  logic [7:0]  ctl_data_o;
  logic        mirror_h_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  write_route_xlate dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference
  int   perm[8] = '{0, 6, 3, 7, 5, 2, 4, 1};
  bit   m_stg = 0;
  int   m_idx = 0;
  bit   m_mir = 0;
  bit   e_we = 0;
  int   e_fn = 0;
  int   e_addr = 0;
  int   e_data = 0;

  function automatic void predict();
    int a = cpu_addr_i;
    int d = cpu_data_i;
    e_we = 0;
    if (!cpu_we_i || a < 'h8000) return;
    if (mode_reg_i == 0 || a >= 'hC000) begin
      e_we = 1; e_fn = 0; e_addr = a; e_data = d;
    end else if ((a & 'hE001) == 'h8000) begin
      e_we = 1; e_fn = 3; e_addr = 'hC000; e_data = d;
    end else if ((a & 'hE001) == 'h8001) begin
      m_idx = perm[d % 8];
      m_stg = 1;
      e_we = 1; e_fn = 1; e_addr = 'h8000; e_data = (d & 'hC0) + m_idx;
    end else if ((a & 'hE001) == 'hA000) begin
      if (m_stg && (!fixed_blk_i || m_idx < 6)) begin
        m_stg = 0;
        e_we = 1; e_fn = 2; e_addr = 'h8001; e_data = d;
      end
    end else begin
      m_mir = d[0];
    end
  endfunction

  task automatic compare(string tag);
    bit bad;
    checks++;
    bad = (ctl_we_o !== e_we) || (mirror_h_o !== m_mir);
    if (e_we && !bad)
      bad = (ctl_fn_o !== 2'(e_fn)) || (ctl_addr_o !== 16'(e_addr)) || (ctl_data_o !== 8'(e_data));
    if (bad) begin
      fails++;
      $display("FAIL %s: got we=%0b fn=%0d addr=%h data=%h mir=%0b, expected we=%0b fn=%0d addr=%h data=%h mir=%0b",
               tag, ctl_we_o, ctl_fn_o, ctl_addr_o, ctl_data_o, mirror_h_o,
               e_we, e_fn, 16'(e_addr), 8'(e_data), m_mir);
    end
  endtask

  task automatic cyc(bit we, logic [15:0] a, logic [7:0] d, string tag);
    cpu_we_i = we; cpu_addr_i = a; cpu_data_i = d;
    predict();
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d, string tag);
    cyc(1, a, d, tag);
    cyc(0, a, d, tag);
  endtask

  task automatic do_reset();
    cpu_we_i = 0;
    rst_ni = 0;
    m_stg = 0; m_idx = 0; m_mir = 0; e_we = 0; e_fn = 0; e_addr = 0; e_data = 0;
    repeat (2) @(negedge clk_i);
    checks++;
    if (ctl_we_o !== 0 || ctl_fn_o !== 0 || ctl_addr_o !== 0 || ctl_data_o !== 0 || mirror_h_o !== 0) begin
      fails++;
      $display("FAIL R9: got we=%0b fn=%0d addr=%h data=%h mir=%0b, expected all zero",
               ctl_we_o, ctl_fn_o, ctl_addr_o, ctl_data_o, mirror_h_o);
    end
    rst_ni = 1;
    @(negedge clk_i);
    compare("R9");
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();

    // R2: mode zero passes everything upward of 0x8000
    mode_reg_i = 0;
    wr(16'h8000, 8'h06, "R2");
    wr(16'h8001, 8'h09, "R2");
    wr(16'hA000, 8'h01, "R2");
    wr(16'hA001, 8'h81, "R2");
    wr(16'h9FFF, 8'h5A, "R2");
    wr(16'hC000, 8'h22, "R3");
    // R1: low addresses and idle produce nothing
    wr(16'h6000, 8'hAB, "R1");
    wr(16'h5001, 8'h08, "R1");
    cyc(0, 16'h8000, 8'h11, "R1");

    // alternate layout
    mode_reg_i = 8'h03;
    wr(16'h8000, 8'h0A, "R4");
    wr(16'h9002, 8'hF0, "R4");
    // R7: data write without staging is dropped
    wr(16'hA000, 8'h01, "R7");
    // R5/R6: every permutation entry, each followed by a data write
    for (int i = 0; i < 8; i++) begin
      wr(16'h8001, 8'(8'hF8 | i), "R5");
      wr(16'hB000, 8'(8'h30 + i), "R6");
      wr(16'hA000, 8'h77, "R7");
    end
    wr(16'h9001, 8'h42, "R5");
    // R8: mirroring
    wr(16'hA001, 8'h01, "R8");
    wr(16'hB001, 8'hFE, "R8");
    wr(16'hA001, 8'h03, "R8");
    // R3: upper region in alternate mode
    wr(16'hC001, 8'h55, "R3");
    wr(16'hE001, 8'h00, "R3");
    wr(16'hFFFE, 8'hA5, "R3");

    // R7: override blocks program-register data, flag survives
    fixed_blk_i = 1;
    wr(16'h8001, 8'h01, "R5");   // index 6
    wr(16'hA000, 8'h07, "R7");
    wr(16'hA000, 8'h08, "R7");
    fixed_blk_i = 0;
    wr(16'hA000, 8'h09, "R7");   // still staged -> forwarded
    fixed_blk_i = 1;
    wr(16'h8001, 8'h03, "R5");   // index 7
    wr(16'hA000, 8'h0B, "R7");
    wr(16'h8001, 8'h02, "R5");   // index 3
    wr(16'hA000, 8'h06, "R6");
    wr(16'h8001, 8'h05, "R5");   // index 2
    wr(16'hA000, 8'h0C, "R6");
    fixed_blk_i = 0;

    // any nonzero mode value selects the alternate layout
    mode_reg_i = 8'h80;
    wr(16'h8000, 8'h33, "R4");

    // R1: back-to-back writes, one strobe each
    mode_reg_i = 8'h01;
    cyc(1, 16'h8001, 8'h06, "R1");
    cyc(1, 16'hA000, 8'h14, "R1");
    cyc(1, 16'hC000, 8'h15, "R1");
    cyc(1, 16'hA001, 8'h00, "R1");
    cyc(0, 16'hA001, 8'h00, "R1");

    // R9: reset clears staging and mirroring
    wr(16'h8001, 8'h00, "R5");
    wr(16'hA001, 8'h01, "R8");
    do_reset();
    wr(16'hA000, 8'h44, "R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule